// File: doc/BRIEF.md
# Instruction Decode Slot Steering

This block sits between a predecoded instruction queue and a decoded-op queue. Each cycle it looks at a window of up to four instructions at the head of the queue, each tagged with the number of micro-ops it expands to and a fused flag. It groups them onto four parallel decode slots in strict program order and emits the resulting micro-ops on a lane bus up to four wide. The slots are not alike. Slot 0 takes any instruction of up to four micro-ops. Slots 1 to 3 take only single-op instructions, and a fused pair counts as one op. An instruction that expands past four micro-ops is handed to a microcode sequencer model, which streams its ops over several cycles. No other instruction is decoded while it runs.

The queue side reports how many head entries were consumed through `in_pop`, and it shifts its window by that amount before the next cycle. Downstream accepts a whole group with `out_ready`. Every micro-op carries a running sequence number, so a consumer can confirm that program order is kept. The micro-ops are synthetic tags: no real decoding takes place.

Top module: `dss_steer`

## Requirements
- R1: After reset, and after a reset applied in the middle of a sequencer run, no sequencer run is active and the first micro-op emitted carries sequence number 0.
- R2: The instruction in window entry 0 with a count of 1 to 4 occupies output lanes 0 upward, one lane per micro-op. Each of those lanes carries that instruction's fused flag. A fused single-op instruction taken in slots 1 to 3 carries its flag on its lane.
- R3: Window entries 1 to 3 are taken only while the instruction has a count of 1 and every earlier entry was taken. The first entry with a count above 1 closes the group. `in_pop` equals the number of entries taken.
- R4: A group never exceeds four micro-op lanes. A single-op entry that would need a fifth lane is left for the next cycle.
- R5: An entry-0 instruction with a count above 4 is consumed at once (`in_pop`=1). It then emits min(remaining, 4) micro-ops per accepted cycle, with `out_ucode` set and `out_fused` clear on those lanes, and `in_pop` is 0 until its last op. Normal steering resumes in the cycle after its last op.
- R6: An instruction with a count above 4 at an entry other than 0 closes the group. It is steered from entry 0 in a later cycle.
- R7: While `out_ready` is low, `in_pop` is 0, the sequence number does not advance and the sequencer's progress holds. The same group stays on the outputs while the inputs are held.
- R8: Valid lanes form a contiguous run from lane 0. Lane j carries the lane-0 sequence number plus j. Each accepted group advances the lane-0 number by the count of valid lanes, modulo 2^SEQW.
- R9: A micro-op count of 0 is steered as a count of 1.

Field positions: window entry k uses `in_vld[k]`, `in_fused[k]` and `in_cnt[k*CNTW +: CNTW]`. Lane j uses `out_vld[j]`, `out_fused[j]`, `out_ucode[j]` and `out_seq[j*SEQW +: SEQW]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | NSLOT | Valid flag per window entry (contiguous from entry 0) |
| in_cnt | input | NSLOT*CNTW | Micro-op count per window entry |
| in_fused | input | NSLOT | Fused flag per window entry |
| in_pop | output | $clog2(NSLOT+1) | Number of head entries consumed this cycle |
| out_ready | input | 1 | Downstream accepts the current group |
| out_vld | output | NSLOT | Valid flag per micro-op lane |
| out_seq | output | NSLOT*SEQW | Sequence number per lane |
| out_fused | output | NSLOT | Lane carries a fused op |
| out_ucode | output | NSLOT | Lane comes from the microcode sequencer |

## Verification
The bench builds the block with the default parameters: four slots, a 5-bit count, a multi-op limit of 4 in slot 0, a sequencer rate of 4 and 8-bit sequence numbers. With counts reaching 31, a sequencer run can end on a full group (count 8) or a partial one (counts 5 and 9). With four lanes, the width cap is reached from heads of 2, 3 and 4 ops. The stimulus also covers a stall in the middle of a sequencer run, and a reset while one is in flight.

// File: rtl/dss_pkg.sv
package dss_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE,
      MODE_SLOTS,
      MODE_UC_START,
      MODE_UC_RUN
   } dss_mode_e;

endpackage

// File: rtl/dss_slot_pick.sv
// Decides how many head entries join this cycle's slot group.
module dss_slot_pick #(
   parameter int NSLOT     = 4,
   parameter int CNTW      = 5,
   parameter int MULTI_MAX = 4,
   parameter int PW        = $clog2(NSLOT + 1)
) (
   input  logic [NSLOT-1:0]      in_vld,
   input  logic [NSLOT*CNTW-1:0] in_cnt,
   output logic [PW-1:0]         take_n,
   output logic [PW-1:0]         lane_n,
   output logic [PW-1:0]         head_lanes,
   output logic                  head_long
);

   logic [CNTW-1:0] eff0;
   logic            open;

   always_comb begin
      take_n     = '0;
      lane_n     = '0;
      head_lanes = '0;
      head_long  = 1'b0;
      open       = 1'b0;
      eff0       = (in_cnt[CNTW-1:0] == '0) ? CNTW'(1) : in_cnt[CNTW-1:0];
      if (in_vld[0]) begin
         if (eff0 > CNTW'(MULTI_MAX)) begin
            head_long = 1'b1;
         end else begin
            head_lanes = PW'(eff0);
            lane_n     = PW'(eff0);
            take_n     = PW'(1);
            open       = 1'b1;
         end
      end
      for (int k = 1; k < NSLOT; k++) begin
         if (open && in_vld[k] && (in_cnt[k*CNTW +: CNTW] <= CNTW'(1))
             && (lane_n < PW'(NSLOT))) begin
            take_n = take_n + PW'(1);
            lane_n = lane_n + PW'(1);
         end else begin
            open = 1'b0;
         end
      end
   end

endmodule

// File: rtl/dss_ucode_seq.sv
// Streams the ops of a long instruction at UC_RATE per accepted cycle.
module dss_ucode_seq #(
   parameter int CNTW    = 5,
   parameter int UC_RATE = 4,
   parameter int PW      = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [CNTW-1:0] start_cnt,
   input  logic            advance,
   output logic            busy,
   output logic [PW-1:0]   emit_n
);

   logic            act;
   logic [CNTW-1:0] rem;
   logic [CNTW-1:0] src;
   logic            engaged;

   assign busy    = act;
   assign engaged = act | start;

   always_comb begin
      src = act ? rem : start_cnt;
      if (!engaged)
         emit_n = '0;
      else if (src > CNTW'(UC_RATE))
         emit_n = PW'(UC_RATE);
      else
         emit_n = PW'(src);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act <= 1'b0;
         rem <= '0;
      end else if (advance && engaged) begin
         rem <= src - CNTW'(emit_n);
         act <= (src > CNTW'(UC_RATE));
      end
   end

endmodule

// File: rtl/dss_lane_fill.sv
// Maps the chosen group or sequencer burst onto output lanes.
module dss_lane_fill #(
   parameter int NSLOT = 4,
   parameter int SEQW  = 8,
   parameter int PW    = 3
) (
   input  logic                  uc_mode,
   input  logic [PW-1:0]         uc_n,
   input  logic [PW-1:0]         norm_n,
   input  logic [PW-1:0]         head_lanes,
   input  logic [NSLOT-1:0]      in_fused,
   input  logic [SEQW-1:0]       seq_base,
   output logic [NSLOT-1:0]      out_vld,
   output logic [NSLOT*SEQW-1:0] out_seq,
   output logic [NSLOT-1:0]      out_fused,
   output logic [NSLOT-1:0]      out_ucode
);

   localparam int IW = $clog2(NSLOT);

   logic [PW-1:0] cap;
   assign cap = uc_mode ? uc_n : norm_n;

   for (genvar j = 0; j < NSLOT; j++) begin : g_lane
      logic          v;
      logic          f;
      int            idx;
      logic [IW-1:0] sel;

      always_comb begin
         v   = PW'(j) < cap;
         idx = (PW'(j) < head_lanes) ? 0 : j - int'(head_lanes) + 1;
         sel = (idx < NSLOT) ? IW'(idx) : '0;
         f   = v && !uc_mode && (idx < NSLOT) && in_fused[sel];
      end

      assign out_vld[j]                = v;
      assign out_fused[j]              = f;
      assign out_ucode[j]              = v & uc_mode;
      assign out_seq[j*SEQW +: SEQW]   = seq_base + SEQW'(j);
   end

endmodule

// File: rtl/dss_steer.sv
module dss_steer
   import dss_pkg::*;
#(
   parameter int NSLOT     = 4,
   parameter int CNTW      = 5,
   parameter int MULTI_MAX = 4,
   parameter int UC_RATE   = 4,
   parameter int SEQW      = 8,
   localparam int PW       = $clog2(NSLOT + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NSLOT-1:0]      in_vld,
   input  logic [NSLOT*CNTW-1:0] in_cnt,
   input  logic [NSLOT-1:0]      in_fused,
   output logic [PW-1:0]         in_pop,
   input  logic                  out_ready,
   output logic [NSLOT-1:0]      out_vld,
   output logic [NSLOT*SEQW-1:0] out_seq,
   output logic [NSLOT-1:0]      out_fused,
   output logic [NSLOT-1:0]      out_ucode
);

   if (NSLOT < 2) begin : g_bad_nslot
      $error("dss_steer: NSLOT must be at least 2");
   end
   if (MULTI_MAX < 1 || MULTI_MAX > NSLOT) begin : g_bad_multi
      $error("dss_steer: MULTI_MAX must lie in 1..NSLOT");
   end
   if (UC_RATE < 1 || UC_RATE > NSLOT) begin : g_bad_rate
      $error("dss_steer: UC_RATE must lie in 1..NSLOT");
   end
   if ((1 << CNTW) <= MULTI_MAX + 1) begin : g_bad_cntw
      $error("dss_steer: CNTW too narrow to express a long instruction");
   end

   logic [PW-1:0]   take_n;
   logic [PW-1:0]   lane_n;
   logic [PW-1:0]   head_lanes;
   logic            head_long;
   logic            uc_busy;
   logic [PW-1:0]   uc_n;
   logic            uc_mode;
   logic [SEQW-1:0] seq_q;
   dss_mode_e       mode;

   dss_slot_pick #(
      .NSLOT(NSLOT), .CNTW(CNTW), .MULTI_MAX(MULTI_MAX), .PW(PW)
   ) u_pick (
      .in_vld(in_vld), .in_cnt(in_cnt), .take_n(take_n),
      .lane_n(lane_n), .head_lanes(head_lanes), .head_long(head_long)
   );

   always_comb begin
      if (uc_busy)        mode = MODE_UC_RUN;
      else if (head_long) mode = MODE_UC_START;
      else if (take_n != '0) mode = MODE_SLOTS;
      else                mode = MODE_IDLE;
   end

   assign uc_mode = (mode == MODE_UC_RUN) || (mode == MODE_UC_START);

   dss_ucode_seq #(
      .CNTW(CNTW), .UC_RATE(UC_RATE), .PW(PW)
   ) u_ucode (
      .clk(clk), .rst_n(rst_n), .start(mode == MODE_UC_START),
      .start_cnt(in_cnt[CNTW-1:0]), .advance(out_ready),
      .busy(uc_busy), .emit_n(uc_n)
   );

   always_comb begin
      in_pop = '0;
      if (out_ready) begin
         case (mode)
            MODE_UC_START: in_pop = PW'(1);
            MODE_SLOTS:    in_pop = take_n;
            default:       in_pop = '0;
         endcase
      end
   end

   dss_lane_fill #(
      .NSLOT(NSLOT), .SEQW(SEQW), .PW(PW)
   ) u_fill (
      .uc_mode(uc_mode), .uc_n(uc_n), .norm_n(lane_n),
      .head_lanes(head_lanes), .in_fused(in_fused), .seq_base(seq_q),
      .out_vld(out_vld), .out_seq(out_seq), .out_fused(out_fused),
      .out_ucode(out_ucode)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         seq_q <= '0;
      else if (out_ready)
         seq_q <= seq_q + SEQW'($countones(out_vld));
   end

endmodule

// File: rtl/dss_steer_chk.sv
module dss_steer_chk #(
   parameter int NSLOT = 4,
   parameter int CNTW  = 5,
   parameter int SEQW  = 8,
   parameter int PW    = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NSLOT*CNTW-1:0] in_cnt,
   input logic [PW-1:0]         in_pop,
   input logic                  out_ready,
   input logic [NSLOT-1:0]      out_vld,
   input logic [NSLOT*SEQW-1:0] out_seq,
   input logic [NSLOT-1:0]      out_ucode
);

   // R7
   pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |-> in_pop == '0);

   // R7
   seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |=> $stable(out_seq[SEQW-1:0]));

   // R8
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |=> out_seq[SEQW-1:0] ==
         $past(out_seq[SEQW-1:0] + SEQW'($countones(out_vld))));

   // R8
   lane_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_vld + NSLOT'(1)) & out_vld) == '0);

   // R5
   uc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[0] && out_ucode[0]) |-> (in_pop <= PW'(1)));

   // R5
   uc_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld[0] && out_ucode[0]) |-> ((out_ucode & out_vld) == out_vld));

   // R3
   slot1_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_pop > PW'(1)) |-> (in_cnt[2*CNTW-1:CNTW] <= CNTW'(1)));

endmodule

bind dss_steer dss_steer_chk #(
   .NSLOT(NSLOT), .CNTW(CNTW), .SEQW(SEQW), .PW(PW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .in_pop(in_pop),
   .out_ready(out_ready), .out_vld(out_vld), .out_seq(out_seq),
   .out_ucode(out_ucode)
);

// File: tb/tb_dss_steer.sv
`timescale 1ns/1ps
module tb_dss_steer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  in_vld = '0;
   logic [19:0] in_cnt = '0;
   logic [3:0]  in_fused = '0;
   logic [2:0]  in_pop;
   logic        out_ready = 1'b1;
   logic [3:0]  out_vld;
   logic [31:0] out_seq;
   logic [3:0]  out_fused;
   logic [3:0]  out_ucode;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] exp_seq = '0;

   always #2.5 clk = ~clk;

   dss_steer dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_cnt(in_cnt),
      .in_fused(in_fused), .in_pop(in_pop), .out_ready(out_ready),
      .out_vld(out_vld), .out_seq(out_seq), .out_fused(out_fused),
      .out_ucode(out_ucode)
   );

   typedef struct packed {
      logic [3:0] rq;
      logic [3:0] vld;
      logic [4:0] c0, c1, c2, c3;
      logic [3:0] fu;
      logic       rdy;
      logic [2:0] pop;
      logic [3:0] ov, ou, of;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t TBL [NV] = '{
      '{4'd3, 4'b1111, 5'd1, 5'd1, 5'd1, 5'd1, 4'b0000, 1'b1, 3'd4, 4'b1111, 4'b0000, 4'b0000}, // R3 four singles
      '{4'd4, 4'b1111, 5'd2, 5'd1, 5'd1, 5'd1, 4'b0001, 1'b1, 3'd3, 4'b1111, 4'b0000, 4'b0011}, // R4 cap, R2 fused head
      '{4'd3, 4'b1111, 5'd1, 5'd2, 5'd1, 5'd1, 4'b0100, 1'b1, 3'd1, 4'b0001, 4'b0000, 4'b0000}, // R3 multi-op at slot 1
      '{4'd7, 4'b1111, 5'd2, 5'd1, 5'd1, 5'd1, 4'b0000, 1'b0, 3'd0, 4'b1111, 4'b0000, 4'b0000}, // R7 stall
      '{4'd4, 4'b1111, 5'd2, 5'd1, 5'd1, 5'd1, 4'b0000, 1'b1, 3'd3, 4'b1111, 4'b0000, 4'b0000}, // R4 after stall
      '{4'd2, 4'b0111, 5'd1, 5'd1, 5'd1, 5'd0, 4'b0010, 1'b1, 3'd3, 4'b0111, 4'b0000, 4'b0010}, // R2 fused in slot 1
      '{4'd4, 4'b0111, 5'd3, 5'd1, 5'd1, 5'd0, 4'b0000, 1'b1, 3'd2, 4'b1111, 4'b0000, 4'b0000}, // R4 3-op head
      '{4'd2, 4'b0011, 5'd4, 5'd1, 5'd0, 5'd0, 4'b0000, 1'b1, 3'd1, 4'b1111, 4'b0000, 4'b0000}, // R2 4-op head
      '{4'd6, 4'b0011, 5'd1, 5'd9, 5'd0, 5'd0, 4'b0000, 1'b1, 3'd1, 4'b0001, 4'b0000, 4'b0000}, // R6 long at slot 1
      '{4'd5, 4'b0011, 5'd9, 5'd1, 5'd0, 5'd0, 4'b0001, 1'b1, 3'd1, 4'b1111, 4'b1111, 4'b0000}, // R5 start 9
      '{4'd7, 4'b0011, 5'd1, 5'd1, 5'd0, 5'd0, 4'b0000, 1'b0, 3'd0, 4'b1111, 4'b1111, 4'b0000}, // R7 stall mid run
      '{4'd5, 4'b0011, 5'd1, 5'd1, 5'd0, 5'd0, 4'b0000, 1'b1, 3'd0, 4'b1111, 4'b1111, 4'b0000}, // R5 second burst
      '{4'd5, 4'b0011, 5'd1, 5'd1, 5'd0, 5'd0, 4'b0000, 1'b1, 3'd0, 4'b0001, 4'b0001, 4'b0000}, // R5 tail of 1
      '{4'd5, 4'b0011, 5'd1, 5'd1, 5'd0, 5'd0, 4'b0000, 1'b1, 3'd2, 4'b0011, 4'b0000, 4'b0000}, // R5 resume
      '{4'd9, 4'b0001, 5'd0, 5'd0, 5'd0, 5'd0, 4'b0000, 1'b1, 3'd1, 4'b0001, 4'b0000, 4'b0000}, // R9 zero count
      '{4'd3, 4'b0000, 5'd0, 5'd0, 5'd0, 5'd0, 4'b0000, 1'b1, 3'd0, 4'b0000, 4'b0000, 4'b0000}, // R3 empty window
      '{4'd5, 4'b0001, 5'd8, 5'd0, 5'd0, 5'd0, 4'b0000, 1'b1, 3'd1, 4'b1111, 4'b1111, 4'b0000}, // R5 start 8
      '{4'd5, 4'b0000, 5'd0, 5'd0, 5'd0, 5'd0, 4'b0000, 1'b1, 3'd0, 4'b1111, 4'b1111, 4'b0000}, // R5 full last burst
      '{4'd5, 4'b0001, 5'd5, 5'd0, 5'd0, 5'd0, 4'b0000, 1'b1, 3'd1, 4'b1111, 4'b1111, 4'b0000}, // R5 start 5
      '{4'd5, 4'b1111, 5'd1, 5'd1, 5'd1, 5'd1, 4'b0000, 1'b1, 3'd0, 4'b0001, 4'b0001, 4'b0000}, // R5 singles wait
      '{4'd8, 4'b1111, 5'd1, 5'd1, 5'd1, 5'd1, 4'b0000, 1'b1, 3'd4, 4'b1111, 4'b0000, 4'b0000}  // R8 resume full
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_seq(input string tag, input logic [3:0] ov);
      for (int j = 0; j < 4; j++) begin
         if (ov[j])
            chk($sformatf("%s seq lane %0d", tag, j), 32'(out_seq[j*8 +: 8]), 32'(8'(exp_seq + 8'(j))));
      end
   endtask

   task automatic drive(input logic [3:0] v, input logic [19:0] c, input logic [3:0] f, input logic r);
      in_vld    = v;
      in_cnt    = c;
      in_fused  = f;
      out_ready = r;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      // R1: reset state
      drive(4'b0000, '0, 4'b0000, 1'b1);
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset out_vld", 32'(out_vld), 32'h0);
      chk("R1 reset in_pop", 32'(in_pop), 32'h0);
      chk("R1 reset seq", 32'(out_seq[7:0]), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(TBL[i].vld, {TBL[i].c3, TBL[i].c2, TBL[i].c1, TBL[i].c0}, TBL[i].fu, TBL[i].rdy);
         #1;
         chk($sformatf("R%0d vec %0d in_pop", TBL[i].rq, i), 32'(in_pop), 32'(TBL[i].pop));
         chk($sformatf("R%0d vec %0d out_vld", TBL[i].rq, i), 32'(out_vld), 32'(TBL[i].ov));
         chk($sformatf("R%0d vec %0d out_ucode", TBL[i].rq, i), 32'(out_ucode), 32'(TBL[i].ou));
         chk($sformatf("R%0d vec %0d out_fused", TBL[i].rq, i), 32'(out_fused), 32'(TBL[i].of));
         check_seq($sformatf("R8 vec %0d", i), TBL[i].ov);
         if (TBL[i].rdy)
            exp_seq = exp_seq + 8'($countones(TBL[i].ov));
      end

      // R1: reset during a sequencer run of 12 ops
      @(negedge clk);
      drive(4'b0001, 20'd12, 4'b0000, 1'b1);
      #1;
      chk("R5 start 12 in_pop", 32'(in_pop), 32'h1);
      @(negedge clk);
      drive(4'b1111, {5'd1, 5'd1, 5'd1, 5'd1}, 4'b0000, 1'b1);
      #1;
      chk("R5 run 12 out_ucode", 32'(out_ucode), 32'hF);
      chk("R5 run 12 in_pop", 32'(in_pop), 32'h0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      exp_seq = '0;
      chk("R1 post reset in_pop", 32'(in_pop), 32'h4);
      chk("R1 post reset out_ucode", 32'(out_ucode), 32'h0);
      chk("R1 post reset out_vld", 32'(out_vld), 32'hF);
      check_seq("R1 post reset", 4'b1111);

      done = 1'b1;
      finish_run();
   end

endmodule